// File: doc/BRIEF.md
# Four-Slot Descriptor and Report Ring Pair

This block is the command and completion queue pair of one channel of a cyclic audio DMA engine. Software places transfer descriptors into a four-slot descriptor ring by writing four 32-bit words, one after another, to a single data port. A transfer engine takes descriptors from the head of that ring through a valid/ready handshake. When a transfer finishes, the engine places a completion report into a four-slot report ring. Software drains each report by reading four 32-bit words, one after another, from a single data port.

Each ring has a status word. It shows the ring's write and read slot pointers, a full flag, an empty flag and a sticky error flag. A control bit holds both rings in reset while it is set. Releasing the bit leaves both rings empty, with the multi-word access counters and the error flags cleared.

Top module: `dma_ring_pair`

## Requirements
- R1: After the asynchronous reset, both status words read 0x100: slots at 0, empty set, full and error clear. The engine sees no descriptor, the engine report side is ready, and the report data port reads 0.
- R2: The software write port is addressed by `sw_sel`, with these codes: 0 is control, 1 is descriptor data, 2 is descriptor-ring status, 3 is report-ring status. A descriptor enters the ring only on the fourth data write. The four words, in write order, are address bits [31:0], address bits [63:32], length, and flags. The first three writes leave the status word and the engine outputs unchanged.
- R3: Each ring holds four entries. With four entries stored, status bit 9 (full) is set and the write slot equals the read slot. A descriptor completed while the ring is full is dropped, and it sets error bit 10.
- R4: In a status word, bits [1:0] are the write slot and bits [5:4] are the read slot. Each slot advances modulo 4 on every accepted push or pop. Bit 8 is empty and bit 9 is full. They are never set together, and occupancy is (write − read) mod 4 whenever the two slots differ.
- R5: `eng_desc_valid` is high exactly when the descriptor ring holds an entry. It presents the oldest entry, and a cycle with valid and ready both high removes that entry.
- R6: `eng_rpt_ready` is low while the report ring is full. A cycle with `eng_rpt_valid` and ready both high stores the report. Software then reads the report as count [31:0], count [63:32], auxiliary word, and flags. The entry leaves the ring on the fourth read.
- R7: A read strobe on the report port while the report ring is empty returns 0. It does not advance the word counter, and it sets error bit 10 of the report status.
- R8: Writing a 1 to bit 10 of a status word clears that ring's error flag. Writing a 0 there leaves the flag unchanged.
- R9: Writing 1 to control bit 0 holds both rings in reset. Both rings empty, their slots return to 0, their errors clear, and partially written or partially read entries are discarded. While the bit is held, descriptor data writes are ignored and `eng_desc_valid` stays low. Writing 0 to the bit releases the reset.
- R10: `eng_desc_notify` reflects bit 16 of the head descriptor's flags word. That bit is the request for a completion notification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_wr | input | 1 | Software write strobe |
| sw_sel | input | 2 | Write target: 0 control, 1 descriptor data, 2 descriptor status, 3 report status |
| sw_wdata | input | WORD_W | Software write data |
| sw_rd | input | 1 | Report data port read strobe (advances one word) |
| sw_rdata | output | WORD_W | Current report word, 0 when the ring is empty |
| desc_status | output | WORD_W | Descriptor ring status word |
| rpt_status | output | WORD_W | Report ring status word |
| eng_desc_valid | output | 1 | Head descriptor available to the engine |
| eng_desc_ready | input | 1 | Engine takes the head descriptor |
| eng_desc_addr | output | 2*WORD_W | Head descriptor address |
| eng_desc_len | output | WORD_W | Head descriptor length |
| eng_desc_flags | output | WORD_W | Head descriptor flags |
| eng_desc_notify | output | 1 | Head descriptor requests notification |
| eng_rpt_valid | input | 1 | Engine offers a completion report |
| eng_rpt_ready | output | 1 | Report ring can accept a report |
| eng_rpt_count | input | 2*WORD_W | Transfer count of the report |
| eng_rpt_aux | input | WORD_W | Auxiliary report word |
| eng_rpt_flags | input | WORD_W | Report flags |

## Verification
The bench builds the block with its defaults: 32-bit words and 2-bit slot pointers, so each ring has four slots. This is the smallest depth at which both rings fill, wrap their pointers and overflow within a few dozen operations. The random phase therefore crosses the pointer wrap many times, and in both rings it lands on the full-with-equal-slots case as well as the empty-with-equal-slots case. The directed cases cover the same states with a partial entry pending when the ring reset arrives.

// File: rtl/ring_pair_pkg.sv
package ring_pair_pkg;
  localparam int ENTRY_WORDS = 4;
  localparam int CNT_W       = 2;
  localparam int ST_RD_LSB   = 4;
  localparam int ST_EMPTY    = 8;
  localparam int ST_FULL     = 9;
  localparam int ST_ERR      = 10;
  localparam int CTL_RST_BIT = 0;
  localparam int NOTIFY_BIT  = 16;

  typedef enum logic [1:0] {
    SEL_CTL   = 2'd0,
    SEL_DESC  = 2'd1,
    SEL_DSTAT = 2'd2,
    SEL_RSTAT = 2'd3
  } sw_sel_e;
endpackage

// File: rtl/ring_store.sv
module ring_store #(
  parameter int ENTRY_W = 128,
  parameter int SLOT_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               push,
  input  logic [ENTRY_W-1:0] push_data,
  input  logic               pop,
  input  logic               err_set,
  input  logic               err_clr,
  output logic [ENTRY_W-1:0] head_data,
  output logic [SLOT_W-1:0]  wr_slot,
  output logic [SLOT_W-1:0]  rd_slot,
  output logic               full,
  output logic               empty,
  output logic               err
);
  localparam int DEPTH = 1 << SLOT_W;

  logic [SLOT_W-1:0]  wr_q, wr_d, rd_q, rd_d;
  logic               full_q, full_d, err_q, err_d;
  logic               do_push, do_pop;
  logic [ENTRY_W-1:0] slot_q [DEPTH];

  assign empty   = (wr_q == rd_q) && !full_q;
  assign do_push = push && !full_q && !clr;
  assign do_pop  = pop && !empty && !clr;

  always_comb begin
    wr_d   = wr_q;
    rd_d   = rd_q;
    full_d = full_q;
    err_d  = err_q;
    if (clr) begin
      wr_d   = '0;
      rd_d   = '0;
      full_d = 1'b0;
      err_d  = 1'b0;
    end else begin
      if (do_push) wr_d = wr_q + SLOT_W'(1);
      if (do_pop)  rd_d = rd_q + SLOT_W'(1);
      if (do_push && !do_pop)      full_d = ((wr_q + SLOT_W'(1)) == rd_q);
      else if (do_pop && !do_push) full_d = 1'b0;
      if (err_set)      err_d = 1'b1;
      else if (err_clr) err_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      full_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      wr_q   <= wr_d;
      rd_q   <= rd_d;
      full_q <= full_d;
      err_q  <= err_d;
    end
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (do_push && (wr_q == SLOT_W'(s))) slot_q[s] <= push_data;
    end
  end

  assign head_data = slot_q[rd_q];
  assign wr_slot   = wr_q;
  assign rd_slot   = rd_q;
  assign full      = full_q;
  assign err       = err_q;
endmodule

// File: rtl/push_assembler.sv
module push_assembler
  import ring_pair_pkg::*;
#(
  parameter int WORD_W  = 32,
  localparam int ENTRY_W = WORD_W * ENTRY_WORDS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               wr_en,
  input  logic [WORD_W-1:0]  wdata,
  output logic               commit,
  output logic [ENTRY_W-1:0] entry
);
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] stage_q [ENTRY_WORDS-1];
  logic              take;

  assign take   = wr_en && !clr;
  assign commit = take && (cnt_q == CNT_W'(ENTRY_WORDS - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (take) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar i = 0; i < ENTRY_WORDS - 1; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (take && (cnt_q == CNT_W'(i))) stage_q[i] <= wdata;
    end
    assign entry[i*WORD_W +: WORD_W] = stage_q[i];
  end
  assign entry[(ENTRY_WORDS-1)*WORD_W +: WORD_W] = wdata;
endmodule

// File: rtl/pop_serializer.sv
module pop_serializer
  import ring_pair_pkg::*;
#(
  parameter int WORD_W  = 32,
  localparam int ENTRY_W = WORD_W * ENTRY_WORDS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               rd_en,
  input  logic               avail,
  input  logic [ENTRY_W-1:0] entry,
  output logic [WORD_W-1:0]  rdata,
  output logic               pop,
  output logic               underflow
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             take;

  assign take      = rd_en && avail && !clr;
  assign pop       = take && (cnt_q == CNT_W'(ENTRY_WORDS - 1));
  assign underflow = rd_en && !avail && !clr;
  assign rdata     = avail ? entry[cnt_q*WORD_W +: WORD_W] : '0;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (take) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dma_ring_pair.sv
module dma_ring_pair
  import ring_pair_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int SLOT_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sw_wr,
  input  logic [1:0]          sw_sel,
  input  logic [WORD_W-1:0]   sw_wdata,
  input  logic                sw_rd,
  output logic [WORD_W-1:0]   sw_rdata,
  output logic [WORD_W-1:0]   desc_status,
  output logic [WORD_W-1:0]   rpt_status,
  output logic                eng_desc_valid,
  input  logic                eng_desc_ready,
  output logic [2*WORD_W-1:0] eng_desc_addr,
  output logic [WORD_W-1:0]   eng_desc_len,
  output logic [WORD_W-1:0]   eng_desc_flags,
  output logic                eng_desc_notify,
  input  logic                eng_rpt_valid,
  output logic                eng_rpt_ready,
  input  logic [2*WORD_W-1:0] eng_rpt_count,
  input  logic [WORD_W-1:0]   eng_rpt_aux,
  input  logic [WORD_W-1:0]   eng_rpt_flags
);
  localparam int ENTRY_W = WORD_W * ENTRY_WORDS;

  sw_sel_e            sel;
  logic               ring_rst_q, ring_rst_d, ctl_we;
  logic               desc_we, dstat_we, rstat_we;
  logic               d_commit, d_full, d_empty, d_err;
  logic [ENTRY_W-1:0] d_entry, d_head;
  logic [SLOT_W-1:0]  d_wr, d_rd;
  logic               r_pop, r_under, r_full, r_empty, r_err;
  logic [ENTRY_W-1:0] r_entry, r_head;
  logic [SLOT_W-1:0]  r_wr, r_rd;

  assign sel      = sw_sel_e'(sw_sel);
  assign ctl_we   = sw_wr && (sel == SEL_CTL);
  assign desc_we  = sw_wr && (sel == SEL_DESC);
  assign dstat_we = sw_wr && (sel == SEL_DSTAT);
  assign rstat_we = sw_wr && (sel == SEL_RSTAT);

  always_comb begin
    ring_rst_d = ring_rst_q;
    if (ctl_we) ring_rst_d = sw_wdata[CTL_RST_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ring_rst_q <= 1'b0;
    else        ring_rst_q <= ring_rst_d;
  end

  push_assembler #(.WORD_W(WORD_W)) u_dasm (
    .clk(clk), .rst_n(rst_n), .clr(ring_rst_q), .wr_en(desc_we),
    .wdata(sw_wdata), .commit(d_commit), .entry(d_entry)
  );

  ring_store #(.ENTRY_W(ENTRY_W), .SLOT_W(SLOT_W)) u_dring (
    .clk(clk), .rst_n(rst_n), .clr(ring_rst_q),
    .push(d_commit), .push_data(d_entry),
    .pop(eng_desc_valid && eng_desc_ready),
    .err_set(d_commit && d_full), .err_clr(dstat_we && sw_wdata[ST_ERR]),
    .head_data(d_head), .wr_slot(d_wr), .rd_slot(d_rd),
    .full(d_full), .empty(d_empty), .err(d_err)
  );

  assign r_entry = {eng_rpt_flags, eng_rpt_aux, eng_rpt_count};

  ring_store #(.ENTRY_W(ENTRY_W), .SLOT_W(SLOT_W)) u_rring (
    .clk(clk), .rst_n(rst_n), .clr(ring_rst_q),
    .push(eng_rpt_valid && eng_rpt_ready), .push_data(r_entry),
    .pop(r_pop),
    .err_set(r_under), .err_clr(rstat_we && sw_wdata[ST_ERR]),
    .head_data(r_head), .wr_slot(r_wr), .rd_slot(r_rd),
    .full(r_full), .empty(r_empty), .err(r_err)
  );

  pop_serializer #(.WORD_W(WORD_W)) u_rser (
    .clk(clk), .rst_n(rst_n), .clr(ring_rst_q), .rd_en(sw_rd),
    .avail(!r_empty), .entry(r_head), .rdata(sw_rdata),
    .pop(r_pop), .underflow(r_under)
  );

  always_comb begin
    desc_status                       = '0;
    desc_status[SLOT_W-1:0]           = d_wr;
    desc_status[ST_RD_LSB +: SLOT_W]  = d_rd;
    desc_status[ST_EMPTY]             = d_empty;
    desc_status[ST_FULL]              = d_full;
    desc_status[ST_ERR]               = d_err;
    rpt_status                        = '0;
    rpt_status[SLOT_W-1:0]            = r_wr;
    rpt_status[ST_RD_LSB +: SLOT_W]   = r_rd;
    rpt_status[ST_EMPTY]              = r_empty;
    rpt_status[ST_FULL]               = r_full;
    rpt_status[ST_ERR]                = r_err;
  end

  assign eng_desc_valid  = !d_empty && !ring_rst_q;
  assign eng_desc_addr   = d_head[2*WORD_W-1:0];
  assign eng_desc_len    = d_head[3*WORD_W-1:2*WORD_W];
  assign eng_desc_flags  = d_head[4*WORD_W-1:3*WORD_W];
  assign eng_desc_notify = eng_desc_flags[NOTIFY_BIT];
  assign eng_rpt_ready   = !r_full && !ring_rst_q;
endmodule

// File: rtl/ring_pair_checker.sv
module ring_pair_checker #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sw_wr,
  input logic [1:0]        sw_sel,
  input logic [WORD_W-1:0] sw_wdata,
  input logic              sw_rd,
  input logic [WORD_W-1:0] desc_status,
  input logic [WORD_W-1:0] rpt_status,
  input logic              eng_desc_valid,
  input logic              eng_rpt_ready
);
  assert_full_slots_equal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    desc_status[9] |-> (desc_status[1:0] == desc_status[5:4]));

  assert_full_empty_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(desc_status[8] && desc_status[9]) && !(rpt_status[8] && rpt_status[9]));

  assert_no_valid_when_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    desc_status[8] |-> !eng_desc_valid);

  assert_no_ready_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_status[9] |-> !eng_rpt_ready);

  assert_err_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && sw_sel == 2'd3 && sw_wdata[10] && !sw_rd) |=> !rpt_status[10]);

  assert_ring_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && sw_sel == 2'd0 && sw_wdata[0]) |=> ##1
      (desc_status[8] && rpt_status[8] && !desc_status[10] && !rpt_status[10]));
endmodule

bind dma_ring_pair ring_pair_checker #(.WORD_W(WORD_W)) u_ring_chk (
  .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_sel(sw_sel),
  .sw_wdata(sw_wdata), .sw_rd(sw_rd), .desc_status(desc_status),
  .rpt_status(rpt_status), .eng_desc_valid(eng_desc_valid),
  .eng_rpt_ready(eng_rpt_ready)
);

// File: tb/dma_ring_pair_test.sv
`timescale 1ns/1ps
module dma_ring_pair_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sw_wr, sw_rd;
  logic [1:0]  sw_sel;
  logic [31:0] sw_wdata, sw_rdata, desc_status, rpt_status;
  logic        eng_desc_valid, eng_desc_ready, eng_desc_notify;
  logic [63:0] eng_desc_addr, eng_rpt_count;
  logic [31:0] eng_desc_len, eng_desc_flags, eng_rpt_aux, eng_rpt_flags;
  logic        eng_rpt_valid, eng_rpt_ready;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [127:0] dq[$];
  logic [127:0] rq[$];
  int dwr, drd, derr, rwr, rrd, rerr;

  always #2.5 clk = ~clk;

  dma_ring_pair uut (.*);

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_stat(int wr, int rd, int cnt, int err);
    logic [31:0] v;
    v = 32'(wr) | (32'(rd) << 4);
    if (cnt == 0) v |= 32'h100;
    if (cnt == 4) v |= 32'h200;
    if (err != 0) v |= 32'h400;
    return v;
  endfunction

  function automatic logic [127:0] rnd_entry();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic check_stat(string req);
    chk(req, 64'(desc_status), 64'(exp_stat(dwr, drd, dq.size(), derr)));
    chk(req, 64'(rpt_status),  64'(exp_stat(rwr, rrd, rq.size(), rerr)));
  endtask

  task automatic sw_write(logic [1:0] sel, logic [31:0] d);
    sw_wr = 1'b1; sw_sel = sel; sw_wdata = d;
    step();
    sw_wr = 1'b0; sw_wdata = '0;
  endtask

  task automatic push_desc(logic [127:0] e);
    for (int i = 0; i < 4; i++) sw_write(2'd1, e[i*32 +: 32]);
    if (dq.size() == 4) derr = 1;
    else begin
      dq.push_back(e);
      dwr = (dwr + 1) % 4;
    end
  endtask

  task automatic eng_take(string req);
    if (dq.size() > 0) begin
      chk(req, 64'(eng_desc_valid), 64'd1);
      chk(req, eng_desc_addr, dq[0][63:0]);
      chk(req, 64'(eng_desc_len), 64'(dq[0][95:64]));
      chk(req, 64'(eng_desc_flags), 64'(dq[0][127:96]));
      chk("R10", 64'(eng_desc_notify), 64'(dq[0][112]));
      eng_desc_ready = 1'b1;
      step();
      eng_desc_ready = 1'b0;
      void'(dq.pop_front());
      drd = (drd + 1) % 4;
    end else begin
      chk(req, 64'(eng_desc_valid), 64'd0);
    end
  endtask

  task automatic eng_report(logic [127:0] e);
    if (rq.size() < 4) begin
      chk("R6", 64'(eng_rpt_ready), 64'd1);
      eng_rpt_count = e[63:0]; eng_rpt_aux = e[95:64]; eng_rpt_flags = e[127:96];
      eng_rpt_valid = 1'b1;
      step();
      eng_rpt_valid = 1'b0;
      rq.push_back(e);
      rwr = (rwr + 1) % 4;
    end else begin
      chk("R6", 64'(eng_rpt_ready), 64'd0);
    end
  endtask

  task automatic sw_pop(string req);
    bit has;
    has = (rq.size() > 0);
    for (int i = 0; i < 4; i++) begin
      if (has) chk(req, 64'(sw_rdata), 64'(rq[0][i*32 +: 32]));
      else begin
        chk("R7", 64'(sw_rdata), 64'd0);
        rerr = 1;
      end
      sw_rd = 1'b1;
      step();
      sw_rd = 1'b0;
    end
    if (has) begin
      void'(rq.pop_front());
      rrd = (rrd + 1) % 4;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [127:0] e;
    int unused_seed;
    unused_seed = $urandom(32'd5150);
    rst_n = 1'b0; sw_wr = 0; sw_rd = 0; sw_sel = 0; sw_wdata = 0;
    eng_desc_ready = 0; eng_rpt_valid = 0; eng_rpt_count = 0;
    eng_rpt_aux = 0; eng_rpt_flags = 0;
    dwr = 0; drd = 0; derr = 0; rwr = 0; rrd = 0; rerr = 0;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1: reset state
    check_stat("R1");
    chk("R1", 64'(eng_desc_valid), 64'd0);
    chk("R1", 64'(eng_rpt_ready), 64'd1);
    chk("R1", 64'(sw_rdata), 64'd0);

    // R2: partial entry does not commit
    e = rnd_entry();
    for (int i = 0; i < 3; i++) sw_write(2'd1, e[i*32 +: 32]);
    check_stat("R2");
    chk("R2", 64'(eng_desc_valid), 64'd0);
    sw_write(2'd1, e[127:96]);
    dq.push_back(e); dwr = 1;
    check_stat("R2");
    eng_take("R2");

    // R10: notify bit both ways, then R5 on empty
    push_desc({32'h0001_0000, 32'h40, 32'h0, 32'h1000});
    push_desc({32'h0000_0000, 32'h80, 32'h1, 32'h2000});
    eng_take("R10");
    eng_take("R10");
    eng_take("R5");
    check_stat("R4");

    // R3: fill, overflow, order
    for (int i = 0; i < 5; i++) push_desc(rnd_entry());
    check_stat("R3");
    for (int i = 0; i < 4; i++) eng_take("R3");
    check_stat("R3");

    // R8: error clear
    sw_write(2'd2, 32'h0);
    check_stat("R8");
    sw_write(2'd2, 32'h400);
    derr = 0;
    check_stat("R8");

    // R6: report fill and drain
    for (int i = 0; i < 5; i++) eng_report(rnd_entry());
    check_stat("R6");
    for (int i = 0; i < 4; i++) sw_pop("R6");
    check_stat("R6");

    // R7: pop empty report ring
    sw_pop("R7");
    check_stat("R7");
    sw_write(2'd3, 32'h400);
    rerr = 0;
    check_stat("R8");

    // R9: ring reset discards partial words and errors
    for (int i = 0; i < 5; i++) push_desc(rnd_entry());
    eng_report(rnd_entry());
    sw_write(2'd1, 32'hDEAD_0001);
    sw_write(2'd1, 32'hDEAD_0002);
    sw_write(2'd0, 32'h1);
    chk("R9", 64'(eng_desc_valid), 64'd0);
    sw_write(2'd1, 32'hDEAD_0003);
    sw_write(2'd0, 32'h0);
    dq.delete(); rq.delete();
    dwr = 0; drd = 0; derr = 0; rwr = 0; rrd = 0; rerr = 0;
    check_stat("R9");
    chk("R9", 64'(eng_desc_valid), 64'd0);
    push_desc(rnd_entry());
    check_stat("R9");
    eng_take("R9");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      case ($urandom % 4)
        0: push_desc(rnd_entry());
        1: eng_take("R5");
        2: eng_report(rnd_entry());
        default: sw_pop("R6");
      endcase
      check_stat("R4");
      if (($urandom % 16) == 0) begin
        sw_write(2'd2, 32'h400); derr = 0;
        sw_write(2'd3, 32'h400); rerr = 0;
        check_stat("R8");
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule